// File: doc/BRIEF.md
# Debug Register Bank

This block is the register file of a processor debug unit. A host, normally a serial debug front end, reaches it through a plain synchronous port that carries a 6-bit word address, a write enable, 16-bit write data and a read enable. Every decoded word is 16 bits wide. The bank holds:

- a read-only identity word built from build parameters;
- a CPU control register with command strobes and a CPU status view;
- a group of memory-access registers;
- four hardware-breakpoint groups;
- a read-only core-numbering word.

Each register keeps only the bits its write mask allows. Command bits turn into single-cycle pulses toward the CPU. Breakpoint status bits are set by hit pulses from the comparators and are cleared by writing a one to them. The stored settings are driven out so that the memory sequencer and the breakpoint comparators can use them. Those two units sit outside the block.

Top module: `dbg_reg_bank`

## Requirements
- R1: After reset all writable registers read zero. The strobe outputs are low, and every configuration output is zero.
- R2: Address 0 reads bits 15:0 and address 1 reads bits 31:16 of a 32-bit identity word, and writes to both are ignored. From bit 31 down, the word packs: program memory bytes/1024 (6 bits), data memory bytes/128 (9 bits), multiplier flag (1), peripheral bytes/512 (7), user version (5), ASIC flag (1), CPU version (3). With the default parameters the word is 0x40210203.
- R3: The control register at address 2 stores write bits 6:3 and drives them on `cpu_cfg_o`. Bits 2:0 and 15:7 read as zero, so a write of 0xFFFF reads back 0x0078.
- R4: A control write with data bit 0, 1 or 2 set drives `halt_o`, `run_o` or `step_o` high for exactly the one cycle after the write edge.
- R5: The status word at address 3 reads the CPU-halted input in bit 0 and the reset-pending input in bit 2. All other bits read zero, and writes are ignored.
- R6: The memory-control register at address 4 keeps write bits 3:1, so a write of 0xFFFF reads back 0x000E.
- R7: Addresses 5, 6 and 7 (memory address, data, count) are full 16-bit registers, each mirrored on its own output.
- R8: Breakpoint group g (g = 0..3) starts at address 8+4g. Its control word at offset 0 keeps 5 bits (0x001F) when range mode is on, which is the default, and 4 bits (0x000F) when it is off.
- R9: The breakpoint address registers at offsets 2 and 3 of each group keep all 16 bits.
- R10: The breakpoint status word at offset 1 has 4 bits. Status bit b of group g is set by `bkpt_hit_i[4g+b]` and cleared by writing 1 to that bit. A hit in the same cycle as the clearing write leaves the bit set.
- R11: Address 24 reads {total core count, instance number}, 0x3412 by default, and writes to it are ignored.
- R12: Addresses 25 to 63 read zero. A write to them changes no register.
- R13: Read data is registered. It shows the register value from before the rd_en edge one cycle later and holds while rd_en is low. A read and a write to the same address in the same cycle therefore return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| cpu_halted_i | input | 1 | CPU is halted |
| cpu_rst_pend_i | input | 1 | CPU reset pending |
| bkpt_hit_i | input | NUM_BKPT*4 | Breakpoint hit pulses, 4 per group |
| halt_o | output | 1 | Halt command pulse |
| run_o | output | 1 | Run command pulse |
| step_o | output | 1 | Single-step command pulse |
| cpu_cfg_o | output | 4 | Stored control bits 6:3 |
| mem_ctl_o | output | 3 | Stored memory-control bits 3:1 |
| mem_addr_o | output | 16 | Memory address register |
| mem_data_o | output | 16 | Memory data register |
| mem_cnt_o | output | 16 | Memory count register |
| bkpt_ctl_o | output | NUM_BKPT*5 | Breakpoint control words, 5 bits per group |
| bkpt_addr0_o | output | NUM_BKPT*16 | Breakpoint address 0 per group |
| bkpt_addr1_o | output | NUM_BKPT*16 | Breakpoint address 1 per group |

## Verification
The bench targets the places where masks and access types differ.

- **Control masking:** all-ones writes to control, memory control and breakpoint control must read back only their kept bits. A design that stored the command bits would read 0x007F instead of 0x0078.
- **Read-only and unmapped words:** a design that let the identity word take writes would return the written data. A design that decoded addresses above 24 by aliasing on the low address bits would corrupt breakpoint group 0 when address 40 is written.
- **Breakpoint status:** the bench sets, clears and races a hit against the clearing write. Clear-over-set priority would lose the hit.
- **Strobes and read timing:** the bench samples each strobe on both of its cycles, so a pulse that is late or held fails. It reads while writing the same address, so a design that forwarded the new data would return it instead of the old value.

// File: rtl/dbg_bank_pkg.sv
package dbg_bank_pkg;
  localparam int DW = 16;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_ID_LO = 6'd0;
  localparam logic [AW-1:0] A_ID_HI = 6'd1;
  localparam logic [AW-1:0] A_CTL   = 6'd2;
  localparam logic [AW-1:0] A_STAT  = 6'd3;
  localparam logic [AW-1:0] A_MCTL  = 6'd4;
  localparam logic [AW-1:0] A_MADR  = 6'd5;
  localparam logic [AW-1:0] A_MDAT  = 6'd6;
  localparam logic [AW-1:0] A_MCNT  = 6'd7;
  localparam logic [AW-1:0] A_CNUM  = 6'd24;

  localparam int BK_BASE    = 8;
  localparam int BK_STRIDE  = 4;
  localparam int BK_STAT_W  = 4;
  localparam int BK_CTL_MAX = 5;

  typedef enum logic [1:0] {
    BK_CTL  = 2'd0,
    BK_STAT = 2'd1,
    BK_ADR0 = 2'd2,
    BK_ADR1 = 2'd3
  } bk_off_e;

  typedef struct packed {
    logic          en;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
  import dbg_bank_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int CFG_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [CMD_W+CFG_W-1:0] wdata_i,
  input  logic                   rd_ctl_i,
  input  logic                   rd_stat_i,
  input  logic                   cpu_halted_i,
  input  logic                   cpu_rst_pend_i,
  output logic [CMD_W-1:0]       cmd_o,
  output logic [CFG_W-1:0]       cfg_o,
  output logic [DW-1:0]          rd_val_o
);
  localparam int PAD_W = DW - CMD_W - CFG_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmd_q <= '0;
    end else begin
      if (wr_i) cfg_q <= wdata_i[CMD_W +: CFG_W];
      cmd_q <= wr_i ? wdata_i[CMD_W-1:0] : '0;
    end
  end

  always_comb begin
    rd_val_o = '0;
    if (rd_ctl_i)
      rd_val_o = {{PAD_W{1'b0}}, cfg_q, {CMD_W{1'b0}}};
    else if (rd_stat_i)
      rd_val_o = {{(DW-3){1'b0}}, cpu_rst_pend_i, 1'b0, cpu_halted_i};
  end

  assign cmd_o = cmd_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/dbg_mem_regs.sv
module dbg_mem_regs
  import dbg_bank_pkg::*;
#(
  parameter int MCTL_LSB = 1,
  parameter int MCTL_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_req_t           wr_i,
  output logic [MCTL_W-1:0] ctl_o,
  output logic [DW-1:0]     addr_o,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     cnt_o,
  output logic [DW-1:0]     rd_val_o
);
  localparam int HI_PAD = DW - MCTL_LSB - MCTL_W;

  logic [MCTL_W-1:0] ctl_q;
  logic [DW-1:0]     addr_q, data_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (wr_i.en) begin
      unique case (wr_i.addr)
        A_MCTL:  ctl_q  <= wr_i.data[MCTL_LSB +: MCTL_W];
        A_MADR:  addr_q <= wr_i.data;
        A_MDAT:  data_q <= wr_i.data;
        A_MCNT:  cnt_q  <= wr_i.data;
        default: ;
      endcase
    end
  end

  // read decode uses the shared port address
  always_comb begin
    unique case (wr_i.addr)
      A_MCTL:  rd_val_o = {{HI_PAD{1'b0}}, ctl_q, {MCTL_LSB{1'b0}}};
      A_MADR:  rd_val_o = addr_q;
      A_MDAT:  rd_val_o = data_q;
      A_MCNT:  rd_val_o = cnt_q;
      default: rd_val_o = '0;
    endcase
  end

  assign ctl_o  = ctl_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dbg_bkpt_grp.sv
module dbg_bkpt_grp
  import dbg_bank_pkg::*;
#(
  parameter int BASE     = 8,
  parameter bit RANGE_EN = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  wr_req_t               wr_i,
  input  logic [BK_STAT_W-1:0]  hit_i,
  output logic [BK_CTL_MAX-1:0] ctl_o,
  output logic [DW-1:0]         adr0_o,
  output logic [DW-1:0]         adr1_o,
  output logic [DW-1:0]         rd_val_o
);
  localparam int          CTL_W = RANGE_EN ? BK_CTL_MAX : BK_CTL_MAX - 1;
  localparam logic [AW-3:0] GRP = (AW-2)'(BASE / BK_STRIDE);

  logic [CTL_W-1:0]     ctl_q;
  logic [BK_STAT_W-1:0] stat_q;
  logic [DW-1:0]        adr0_q, adr1_q;
  logic                 hit_grp;
  bk_off_e              off;
  logic [BK_STAT_W-1:0] clr;

  assign hit_grp = (wr_i.addr[AW-1:2] == GRP);
  assign off     = bk_off_e'(wr_i.addr[1:0]);
  assign clr     = (wr_i.en && hit_grp && off == BK_STAT) ? wr_i.data[BK_STAT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      adr0_q <= '0;
      adr1_q <= '0;
    end else if (wr_i.en && hit_grp) begin
      unique case (off)
        BK_CTL:  ctl_q  <= wr_i.data[CTL_W-1:0];
        BK_ADR0: adr0_q <= wr_i.data;
        BK_ADR1: adr1_q <= wr_i.data;
        default: ;
      endcase
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | hit_i;
  end

  always_comb begin
    rd_val_o = '0;
    if (hit_grp) begin
      unique case (off)
        BK_CTL:  rd_val_o = {{(DW-CTL_W){1'b0}}, ctl_q};
        BK_STAT: rd_val_o = {{(DW-BK_STAT_W){1'b0}}, stat_q};
        BK_ADR0: rd_val_o = adr0_q;
        BK_ADR1: rd_val_o = adr1_q;
        default: rd_val_o = '0;
      endcase
    end
  end

  generate
    if (RANGE_EN) begin : g_range
      assign ctl_o = ctl_q;
    end else begin : g_norange
      assign ctl_o = {1'b0, ctl_q};
    end
  endgenerate

  assign adr0_o = adr0_q;
  assign adr1_o = adr1_q;
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_bank_pkg::*;
#(
  parameter int          PMEM_BYTES = 16384,
  parameter int          DMEM_BYTES = 2048,
  parameter int          PER_BYTES  = 512,
  parameter bit          MUL_EN     = 1'b1,
  parameter bit          ASIC_EN    = 1'b0,
  parameter logic [4:0]  USER_VER   = 5'd0,
  parameter logic [2:0]  CPU_VER    = 3'd3,
  parameter logic [7:0]  CORE_TOTAL = 8'h34,
  parameter logic [7:0]  CORE_INST  = 8'h12,
  parameter bit          RANGE_EN   = 1'b1,
  parameter int          NUM_BKPT   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [AW-1:0]                  addr_i,
  input  logic                           wr_en_i,
  input  logic [DW-1:0]                  wdata_i,
  input  logic                           rd_en_i,
  output logic [DW-1:0]                  rdata_o,
  input  logic                           cpu_halted_i,
  input  logic                           cpu_rst_pend_i,
  input  logic [NUM_BKPT*BK_STAT_W-1:0]  bkpt_hit_i,
  output logic                           halt_o,
  output logic                           run_o,
  output logic                           step_o,
  output logic [3:0]                     cpu_cfg_o,
  output logic [2:0]                     mem_ctl_o,
  output logic [DW-1:0]                  mem_addr_o,
  output logic [DW-1:0]                  mem_data_o,
  output logic [DW-1:0]                  mem_cnt_o,
  output logic [NUM_BKPT*BK_CTL_MAX-1:0] bkpt_ctl_o,
  output logic [NUM_BKPT*DW-1:0]         bkpt_addr0_o,
  output logic [NUM_BKPT*DW-1:0]         bkpt_addr1_o
);
  localparam logic [5:0] PMEM_F = 6'(PMEM_BYTES / 1024);
  localparam logic [8:0] DMEM_F = 9'(DMEM_BYTES / 128);
  localparam logic [6:0] PER_F  = 7'(PER_BYTES / 512);

  logic [2*DW-1:0] id_word;
  logic [DW-1:0]   cnum_word;
  wr_req_t         wr_req;
  logic [2:0]      cmd;
  logic [DW-1:0]   ctl_rd, mem_rd, fix_rd, bk_or, rd_mux;
  logic [DW-1:0]   bk_rd [NUM_BKPT];

  assign id_word   = {PMEM_F, DMEM_F, MUL_EN, PER_F, USER_VER, ASIC_EN, CPU_VER};
  assign cnum_word = {CORE_TOTAL, CORE_INST};

  assign wr_req.en   = wr_en_i;
  assign wr_req.addr = addr_i;
  assign wr_req.data = wdata_i;

  dbg_ctl_regs #(.CMD_W(3), .CFG_W(4)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_en_i && addr_i == A_CTL),
    .wdata_i       (wdata_i[6:0]),
    .rd_ctl_i      (addr_i == A_CTL),
    .rd_stat_i     (addr_i == A_STAT),
    .cpu_halted_i  (cpu_halted_i),
    .cpu_rst_pend_i(cpu_rst_pend_i),
    .cmd_o         (cmd),
    .cfg_o         (cpu_cfg_o),
    .rd_val_o      (ctl_rd)
  );

  assign halt_o = cmd[0];
  assign run_o  = cmd[1];
  assign step_o = cmd[2];

  dbg_mem_regs #(.MCTL_LSB(1), .MCTL_W(3)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_req),
    .ctl_o   (mem_ctl_o),
    .addr_o  (mem_addr_o),
    .data_o  (mem_data_o),
    .cnt_o   (mem_cnt_o),
    .rd_val_o(mem_rd)
  );

  generate
    for (genvar g = 0; g < NUM_BKPT; g++) begin : g_bk
      dbg_bkpt_grp #(.BASE(BK_BASE + g*BK_STRIDE), .RANGE_EN(RANGE_EN)) u_grp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_req),
        .hit_i   (bkpt_hit_i[g*BK_STAT_W +: BK_STAT_W]),
        .ctl_o   (bkpt_ctl_o[g*BK_CTL_MAX +: BK_CTL_MAX]),
        .adr0_o  (bkpt_addr0_o[g*DW +: DW]),
        .adr1_o  (bkpt_addr1_o[g*DW +: DW]),
        .rd_val_o(bk_rd[g])
      );
    end
  endgenerate

  always_comb begin
    bk_or = '0;
    for (int g = 0; g < NUM_BKPT; g++) bk_or = bk_or | bk_rd[g];
  end

  always_comb begin
    unique case (addr_i)
      A_ID_LO: fix_rd = id_word[DW-1:0];
      A_ID_HI: fix_rd = id_word[2*DW-1:DW];
      A_CNUM:  fix_rd = cnum_word;
      default: fix_rd = '0;
    endcase
  end

  // each source returns zero off its own addresses
  assign rd_mux = fix_rd | ctl_rd | mem_rd | bk_or;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/dbg_reg_bank_chk.sv
module dbg_reg_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [5:0]  addr_i,
  input logic        wr_en_i,
  input logic [15:0] wdata_i,
  input logic        rd_en_i,
  input logic [15:0] rdata_o,
  input logic        cpu_halted_i,
  input logic        cpu_rst_pend_i,
  input logic        halt_o,
  input logic        run_o,
  input logic        step_o,
  input logic [31:0] id_word_i,
  input logic [15:0] cnum_word_i
);
  // R4
  halt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> $past(wr_en_i && addr_i == 6'd2 && wdata_i[0]));
  // R4
  run_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> $past(wr_en_i && addr_i == 6'd2 && wdata_i[1]));
  // R4
  step_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(wr_en_i && addr_i == 6'd2 && wdata_i[2]));
  // R3
  ctl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 6'd2) |=> (rdata_o[2:0] == 3'b0 && rdata_o[15:7] == 9'b0));
  // R5
  stat_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 6'd3) |=>
      rdata_o == {13'b0, $past(cpu_rst_pend_i), 1'b0, $past(cpu_halted_i)});
  // R2
  id_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 6'd0) |=> rdata_o == $past(id_word_i[15:0]));
  // R11
  cnum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 6'd24) |=> rdata_o == $past(cnum_word_i));
  // R12
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > 6'd24) |=> rdata_o == 16'h0000);
  // R13
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind dbg_reg_bank dbg_reg_bank_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .wdata_i       (wdata_i),
  .rd_en_i       (rd_en_i),
  .rdata_o       (rdata_o),
  .cpu_halted_i  (cpu_halted_i),
  .cpu_rst_pend_i(cpu_rst_pend_i),
  .halt_o        (halt_o),
  .run_o         (run_o),
  .step_o        (step_o),
  .id_word_i     (id_word),
  .cnum_word_i   (cnum_word)
);

// File: tb/tb_dbg_reg_bank.sv
`timescale 1ns/1ps
module tb_dbg_reg_bank;
  localparam int NB = 4;
  // default build: 16 KiB pmem, 2 KiB dmem, mul, 512 B periph, cpu ver 3
  localparam logic [15:0] EXP_ID_LO = 16'h0203;
  localparam logic [15:0] EXP_ID_HI = 16'h4021;
  localparam logic [15:0] EXP_CNUM  = 16'h3412;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          halted = 1'b0, rst_pend = 1'b0;
  logic [NB*4-1:0] hit = '0;
  logic          halt, run, step;
  logic [3:0]    cfg;
  logic [2:0]    mctl;
  logic [15:0]   madr, mdat, mcnt;
  logic [NB*5-1:0]  bctl;
  logic [NB*16-1:0] badr0, badr1;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_reg_bank #(.NUM_BKPT(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .cpu_halted_i(halted), .cpu_rst_pend_i(rst_pend),
    .bkpt_hit_i(hit), .halt_o(halt), .run_o(run), .step_o(step), .cpu_cfg_o(cfg),
    .mem_ctl_o(mctl), .mem_addr_o(madr), .mem_data_o(mdat), .mem_cnt_o(mcnt),
    .bkpt_ctl_o(bctl), .bkpt_addr0_o(badr0), .bkpt_addr1_o(badr1)
  );

  // {addr, wdata, expected readback}
  localparam int NV = 22;
  localparam logic [37:0] VEC [NV] = '{
    {6'd2,  16'hFFFF, 16'h0078},
    {6'd4,  16'hFFFF, 16'h000E},
    {6'd5,  16'hA5C3, 16'hA5C3},
    {6'd6,  16'h1234, 16'h1234},
    {6'd7,  16'hFFFF, 16'hFFFF},
    {6'd8,  16'hFFFF, 16'h001F},
    {6'd10, 16'hBEEF, 16'hBEEF},
    {6'd11, 16'hFFFF, 16'hFFFF},
    {6'd12, 16'hFFFF, 16'h001F},
    {6'd14, 16'h0001, 16'h0001},
    {6'd16, 16'h00F0, 16'h0010},
    {6'd19, 16'h8000, 16'h8000},
    {6'd20, 16'hFFFF, 16'h001F},
    {6'd23, 16'h5A5A, 16'h5A5A},
    {6'd9,  16'hFFFF, 16'h0000},
    {6'd21, 16'hFFFF, 16'h0000},
    {6'd0,  16'hFFFF, EXP_ID_LO},
    {6'd1,  16'hFFFF, EXP_ID_HI},
    {6'd24, 16'hFFFF, EXP_CNUM},
    {6'd3,  16'hFFFF, 16'h0000},
    {6'd25, 16'hFFFF, 16'h0000},
    {6'd63, 16'hFFFF, 16'h0000}
  };

  function automatic string req_of(input logic [5:0] a);
    if (a <= 6'd1) return "R2";
    if (a == 6'd2) return "R3";
    if (a == 6'd3) return "R5";
    if (a == 6'd4) return "R6";
    if (a <= 6'd7) return "R7";
    if (a == 6'd24) return "R11";
    if (a > 6'd24) return "R12";
    case (a[1:0])
      2'd0:    return "R8";
      2'd1:    return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R13 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", {13'b0, halt, run, step}, 16'h0);
    chk("R1", {cfg, 9'b0, mctl}, 16'h0);
    chk("R1", madr | mdat | mcnt, 16'h0);
    chk("R1", 16'(bctl) | badr0[15:0] | badr1[63:48], 16'h0);
    for (int a = 2; a < 24; a++) begin
      rd(6'(a), v);
      chk("R1", v, 16'h0);
    end

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][37:32], VEC[i][31:16]);
      rd(VEC[i][37:32], v);
      chk(req_of(VEC[i][37:32]), v, VEC[i][15:0]);
    end
    chk("R3", {12'b0, cfg}, 16'h000F);
    chk("R6", {13'b0, mctl}, 16'h0007);
    chk("R7", madr, 16'hA5C3);
    chk("R9", badr0[31:16], 16'h0001);
    chk("R8", {11'b0, bctl[19:15]}, 16'h001F);

    // R4 strobes: high one cycle after the write edge, then low
    wr(6'd2, 16'h0001);
    chk("R4", {13'b0, halt, run, step}, 16'h0004);
    @(negedge clk);
    chk("R4", {13'b0, halt, run, step}, 16'h0000);
    wr(6'd2, 16'h0002);
    chk("R4", {13'b0, halt, run, step}, 16'h0002);
    @(negedge clk);
    chk("R4", {13'b0, halt, run, step}, 16'h0000);
    wr(6'd2, 16'h0004);
    chk("R4", {13'b0, halt, run, step}, 16'h0001);
    @(negedge clk);
    chk("R4", {13'b0, halt, run, step}, 16'h0000);

    // R5 status view
    halted = 1'b1; rst_pend = 1'b1;
    rd(6'd3, v); chk("R5", v, 16'h0005);
    halted = 1'b0;
    rd(6'd3, v); chk("R5", v, 16'h0004);
    rst_pend = 1'b0;

    // R10 hit set, W1C, hit wins over clear
    @(negedge clk); hit[6] = 1'b1;
    @(negedge clk); hit[6] = 1'b0;
    rd(6'd13, v); chk("R10", v, 16'h0004);
    wr(6'd13, 16'h0001);
    rd(6'd13, v); chk("R10", v, 16'h0004);
    wr(6'd13, 16'h0004);
    rd(6'd13, v); chk("R10", v, 16'h0000);
    @(negedge clk); hit[6] = 1'b1; hit[0] = 1'b1;
    @(negedge clk); hit[0] = 1'b0;
    addr = 6'd13; wdata = 16'hFFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; hit[6] = 1'b0;
    rd(6'd13, v); chk("R10", v, 16'h0004);
    rd(6'd9, v);  chk("R10", v, 16'h0001);

    // R12 writes above 24 must not alias onto group 0
    wr(6'd8, 16'h0000);
    wr(6'd40, 16'hFFFF);
    rd(6'd8, v);  chk("R12", v, 16'h0000);
    rd(6'd40, v); chk("R12", v, 16'h0000);

    // R13 hold and read-before-write
    rd(6'd5, v); chk("R13", v, 16'hA5C3);
    wr(6'd5, 16'h1111);
    chk("R13", rdata, 16'hA5C3);
    @(negedge clk);
    addr = 6'd5; wdata = 16'h2222; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R13", rdata, 16'h1111);
    rd(6'd5, v); chk("R13", v, 16'h2222);

    // R2 identity untouched by writes
    wr(6'd1, 16'h0000);
    rd(6'd1, v); chk("R2", v, EXP_ID_HI);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule